// File: doc/BRIEF.md
# Configurable Synchronous Serial Framer

This block is the serial engine of a codec-style audio port. It takes parallel words from a producer and shifts them out on a transmit data line. It also captures words from a receive data line. Both directions share one externally supplied serial bit clock, which the block oversamples with its own system clock. The transmit side generates a frame sync. The receive side recognises an incoming frame sync and uses it to find the first bit of each word.

A frame always spans `FRAME_BITS` bit slots and carries one word in its leading slots. The remaining slots are idle, so a word-long sync always drops between frames and its leading edge can be found.

Static control inputs set the following:
- the bit order;
- the word length;
- the sync length, chosen separately for each direction;
- whether a word-long sync starts one slot early;
- the sync polarity.

Words enter and leave through single-entry valid/ready registers. A missed transmit word is reported as underrun. An uncollected receive word is reported as overrun.

Top module: `ssi_framer`

## Requirements
- R1: Transmit data carries the low W bits of the loaded word in slots 0..W-1 of each frame, and is 0 in the other slots. Word-length code 000 gives W=8, 001 gives W=12, 010 gives W=16, and every other code gives W=24. With the bit-order input at 1 the least significant bit goes first; at 0 the most significant of the W bits goes first.
- R2: The receiver assembles W bits using the same bit-order input. It presents them right-justified and zero-extended on the 24-bit receive word.
- R3: The 2-bit sync-length code selects the receive and transmit sync lengths: 00 word/word, 01 word/bit, 10 bit/bit, 11 bit/word. A bit-long sync is active for exactly slot 0. A word-long sync is active for W slots.
- R4: With the early-sync input at 1, a word-long sync covers the last slot of the previous frame and slots 0..W-2. With it at 0, the sync covers slots 0..W-1. A bit-long sync ignores this input on both paths.
- R5: With the polarity input at 0 both syncs are active high. At 1 both are active low.
- R6: A frame is `FRAME_BITS` slots long. Transmit outputs change only after a rising bit-clock edge. Receive data and sync are sampled on the falling edge. The first transmit slot after reset is the last slot of a frame.
- R7: `tx_ready` is high while the holding register is empty. A word is accepted when `tx_valid` and `tx_ready` are both high, and it is moved to the shifter at the next frame start.
- R8: When the holding register is empty at a frame start, `tx_underrun` pulses for one clock and the previous word is sent again.
- R9: A finished receive word raises `rx_valid`, which stays high until `rx_ready` is seen. If a new word completes while `rx_valid` is high and `rx_ready` is low, `rx_overrun` pulses for one clock and the new word replaces the old one.
- R10: While reset is asserted, all controls act as zero (word-length code 000). During reset `tx_fs` and `tx_data` are low, `tx_ready` is high, and `rx_valid`, `tx_underrun` and `rx_overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial bit clock |
| cfg_lsb_first | input | 1 | Bit order: 1 least significant first |
| cfg_fs_len | input | 2 | Sync-length code for receive/transmit |
| cfg_fs_early | input | 1 | Word-long sync starts one slot early |
| cfg_fs_active_low | input | 1 | Sync polarity: 1 active low |
| cfg_word_len | input | 3 | Word-length code |
| tx_word | input | 24 | Parallel word to transmit |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding register empty |
| tx_data | output | 1 | Serial transmit data |
| tx_fs | output | 1 | Generated transmit frame sync |
| tx_underrun | output | 1 | One-clock pulse: no word at frame start |
| rx_data | input | 1 | Serial receive data |
| rx_fs | input | 1 | Incoming receive frame sync |
| rx_word | output | 24 | Received word, right-justified |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the received word |
| rx_overrun | output | 1 | One-clock pulse: unread word replaced |

## Verification
The assertions assume that the bit clock is slow next to the system clock, with each phase several clocks long. This keeps underrun and overrun pulses far apart and makes every transmit change follow a detected rising edge. They also assume the controls are held steady while frames run. The stimulus respects both assumptions. It holds each bit-clock phase for four system clocks and changes drive only on falling system-clock edges. It sets the controls and preloads a word before the first bit-clock edge, then resets between table entries.

// File: rtl/ssi_pkg.sv
package ssi_pkg;

    localparam int WORD_MAX = 24;
    localparam int IDX_W    = $clog2(WORD_MAX);
    localparam int LEN_W    = $clog2(WORD_MAX + 1);

    typedef logic [WORD_MAX-1:0] word_t;
    typedef logic [LEN_W-1:0]    wlen_t;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_ARMED = 2'd1,
        RX_SHIFT = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic  lsb_first;
        logic  rx_bit_sync;
        logic  tx_bit_sync;
        logic  fs_early;
        logic  fs_active_low;
        wlen_t wlen;
    } cfg_t;

    // Word-length code to bit count; unlisted codes select the maximum.
    function automatic wlen_t decode_wlen(input logic [2:0] code);
        case (code)
            3'b000:  return wlen_t'(8);
            3'b001:  return wlen_t'(12);
            3'b010:  return wlen_t'(16);
            default: return wlen_t'(WORD_MAX);
        endcase
    endfunction

    // Whether a sync is active in a slot, before polarity is applied.
    function automatic logic sync_window(input logic bit_sync, input logic early,
                                         input int unsigned slot, input int unsigned wl,
                                         input int unsigned frame);
        if (bit_sync)
            return slot == 0;
        else if (early)
            return (slot == frame - 1) || (slot < wl - 1);
        else
            return slot < wl;
    endfunction

endpackage

// File: rtl/ssi_edge_detect.sv
module ssi_edge_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], sclk};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    // chain_q[STAGES-1] is the synchronised level, chain_q[STAGES] its delayed copy.
    assign rise =  chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall = ~chain_q[STAGES-1] &  chain_q[STAGES];

endmodule

// File: rtl/ssi_tx.sv
module ssi_tx
    import ssi_pkg::*;
#(
    parameter int FRAME_BITS = 32
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bit_rise,
    input  logic  lsb_first,
    input  logic  bit_sync,
    input  logic  fs_early,
    input  wlen_t wlen,
    input  word_t tx_word,
    input  logic  tx_valid,
    output logic  tx_ready,
    output logic  tx_data,
    output logic  fs_raw,
    output logic  tx_underrun
);
    localparam int POS_W = $clog2(FRAME_BITS);
    localparam logic [POS_W-1:0] LAST_SLOT = POS_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        word_t            cur;
        word_t            hold;
        logic             hold_full;
        logic             data;
        logic             fs;
        logic             underrun;
    } tx_state_t;

    tx_state_t        st_d, st_q;
    logic [POS_W-1:0] nxt_pos;
    logic [IDX_W-1:0] idx;
    word_t            word_now;
    logic             accept;

    always_comb begin
        st_d          = st_q;
        st_d.underrun = 1'b0;
        accept        = tx_valid & ~st_q.hold_full;
        nxt_pos       = (st_q.pos == LAST_SLOT) ? '0 : st_q.pos + 1'b1;
        word_now      = st_q.cur;
        idx           = lsb_first ? IDX_W'(nxt_pos)
                                  : IDX_W'(int'(wlen) - 1 - int'(nxt_pos));
        if (bit_rise) begin
            st_d.pos = nxt_pos;
            if (nxt_pos == '0) begin
                if (st_q.hold_full) begin
                    word_now       = st_q.hold;
                    st_d.hold_full = 1'b0;
                end else begin
                    st_d.underrun  = 1'b1;
                end
                st_d.cur = word_now;
            end
            st_d.data = (int'(nxt_pos) < int'(wlen)) ? word_now[idx] : 1'b0;
            st_d.fs   = sync_window(bit_sync, fs_early, int'(nxt_pos), int'(wlen), FRAME_BITS);
        end
        if (accept) begin
            st_d.hold      = tx_word;
            st_d.hold_full = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.pos <= POS_W'(FRAME_BITS - 2);
        end else begin
            st_q     <= st_d;
        end
    end

    assign tx_ready    = ~st_q.hold_full;
    assign tx_data     = st_q.data;
    assign fs_raw      = st_q.fs;
    assign tx_underrun = st_q.underrun;

endmodule

// File: rtl/ssi_rx.sv
module ssi_rx
    import ssi_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bit_fall,
    input  logic  lsb_first,
    input  logic  bit_sync,
    input  logic  fs_early,
    input  logic  fs_active_low,
    input  wlen_t wlen,
    input  logic  rx_data,
    input  logic  rx_fs,
    output word_t rx_word,
    output logic  rx_valid,
    input  logic  rx_ready,
    output logic  rx_overrun
);
    typedef struct packed {
        rx_state_e state;
        wlen_t     cnt;
        word_t     acc;
        logic      fs_prev;
        word_t     word;
        logic      valid;
        logic      overrun;
    } rx_reg_t;

    rx_reg_t          st_d, st_q;
    logic             fs_on, lead, start, take;
    wlen_t            bit_pos;
    word_t            acc_new;
    logic [IDX_W-1:0] idx;

    always_comb begin
        st_d         = st_q;
        st_d.overrun = 1'b0;
        fs_on        = rx_fs ^ fs_active_low;
        lead         = fs_on & ~st_q.fs_prev;
        start        = 1'b0;
        take         = 1'b0;
        if (st_q.valid && rx_ready) st_d.valid = 1'b0;

        if (bit_fall) begin
            st_d.fs_prev = fs_on;
            case (st_q.state)
                RX_IDLE: begin
                    if (lead) begin
                        if (!bit_sync && fs_early) st_d.state = RX_ARMED;
                        else                        start      = 1'b1;
                    end
                end
                RX_ARMED: start = 1'b1;
                RX_SHIFT: take  = 1'b1;
                default:  st_d.state = RX_IDLE;
            endcase
        end

        bit_pos = start ? '0 : st_q.cnt;
        acc_new = start ? '0 : st_q.acc;
        idx     = lsb_first ? IDX_W'(bit_pos) : IDX_W'(wlen - 1'b1 - bit_pos);
        acc_new[idx] = rx_data;

        if (start || take) begin
            if (bit_pos == wlen - 1'b1) begin
                st_d.word  = acc_new;
                st_d.valid = 1'b1;
                st_d.state = RX_IDLE;
                if (st_q.valid && !rx_ready) st_d.overrun = 1'b1;
            end else begin
                st_d.acc   = acc_new;
                st_d.cnt   = bit_pos + 1'b1;
                st_d.state = RX_SHIFT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= RX_IDLE;
        end else begin
            st_q       <= st_d;
        end
    end

    assign rx_word    = st_q.word;
    assign rx_valid   = st_q.valid;
    assign rx_overrun = st_q.overrun;

endmodule

// File: rtl/ssi_framer.sv
module ssi_framer
    import ssi_pkg::*;
#(
    parameter int FRAME_BITS  = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk,
    input  logic                cfg_lsb_first,
    input  logic [1:0]          cfg_fs_len,
    input  logic                cfg_fs_early,
    input  logic                cfg_fs_active_low,
    input  logic [2:0]          cfg_word_len,
    input  logic [WORD_MAX-1:0] tx_word,
    input  logic                tx_valid,
    output logic                tx_ready,
    output logic                tx_data,
    output logic                tx_fs,
    output logic                tx_underrun,
    input  logic                rx_data,
    input  logic                rx_fs,
    output logic [WORD_MAX-1:0] rx_word,
    output logic                rx_valid,
    input  logic                rx_ready,
    output logic                rx_overrun
);
    localparam cfg_t CFG_RESET = '{lsb_first: 1'b0, rx_bit_sync: 1'b0, tx_bit_sync: 1'b0,
                                   fs_early: 1'b0, fs_active_low: 1'b0,
                                   wlen: decode_wlen(3'b000)};

    cfg_t cfg_d, cfg_q;
    logic sclk_rise, sclk_fall;
    logic tx_fs_raw;

    always_comb begin
        cfg_d.lsb_first     = cfg_lsb_first;
        cfg_d.rx_bit_sync   = cfg_fs_len[1];
        cfg_d.tx_bit_sync   = cfg_fs_len[1] ^ cfg_fs_len[0];
        cfg_d.fs_early      = cfg_fs_early;
        cfg_d.fs_active_low = cfg_fs_active_low;
        cfg_d.wlen          = decode_wlen(cfg_word_len);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    ssi_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .rise  (sclk_rise),
        .fall  (sclk_fall)
    );

    ssi_tx #(.FRAME_BITS(FRAME_BITS)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_rise    (sclk_rise),
        .lsb_first   (cfg_q.lsb_first),
        .bit_sync    (cfg_q.tx_bit_sync),
        .fs_early    (cfg_q.fs_early),
        .wlen        (cfg_q.wlen),
        .tx_word     (tx_word),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .tx_data     (tx_data),
        .fs_raw      (tx_fs_raw),
        .tx_underrun (tx_underrun)
    );

    ssi_rx u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_fall      (sclk_fall),
        .lsb_first     (cfg_q.lsb_first),
        .bit_sync      (cfg_q.rx_bit_sync),
        .fs_early      (cfg_q.fs_early),
        .fs_active_low (cfg_q.fs_active_low),
        .wlen          (cfg_q.wlen),
        .rx_data       (rx_data),
        .rx_fs         (rx_fs),
        .rx_word       (rx_word),
        .rx_valid      (rx_valid),
        .rx_ready      (rx_ready),
        .rx_overrun    (rx_overrun)
    );

    assign tx_fs = tx_fs_raw ^ cfg_q.fs_active_low;

endmodule

// File: rtl/ssi_framer_chk.sv
module ssi_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_rise,
    input logic tx_valid,
    input logic tx_ready,
    input logic tx_data,
    input logic tx_underrun,
    input logic rx_valid,
    input logic rx_ready,
    input logic rx_overrun
);
    // R7: an accepted word fills the holding register
    a_r7_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready |=> !tx_ready);

    // R6: serial data moves only after a detected rising bit-clock edge
    a_r6_tx_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_rise |=> $stable(tx_data));

    // R8: underrun is a single-clock pulse
    a_r8_underrun_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun |=> !tx_underrun);

    // R9: overrun is a single-clock pulse
    a_r9_overrun_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |=> !rx_overrun);

    // R9: an unread word stays presented
    a_r9_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !rx_ready |=> rx_valid);
endmodule

bind ssi_framer ssi_framer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_rise    (sclk_rise),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_data     (tx_data),
    .tx_underrun (tx_underrun),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .rx_overrun  (rx_overrun)
);

// File: tb/ssi_framer_test.sv
module ssi_framer_test;
    localparam int FRAME = 32;
    localparam int NVEC  = 8;

    // {lsb, fs_len[1:0], early, active_low, wl_code[2:0], word[23:0]}
    localparam logic [31:0] VECS [NVEC] = '{
        {1'b0, 2'b00, 1'b0, 1'b0, 3'b010, 24'h00C3A5},
        {1'b1, 2'b00, 1'b0, 1'b0, 3'b000, 24'h5A5AB4},
        {1'b0, 2'b01, 1'b1, 1'b0, 3'b001, 24'h777ABC},
        {1'b1, 2'b10, 1'b1, 1'b1, 3'b011, 24'h9A3C5E},
        {1'b0, 2'b11, 1'b1, 1'b0, 3'b111, 24'hF0E1D2},
        {1'b1, 2'b11, 1'b0, 1'b1, 3'b101, 24'h123456},
        {1'b0, 2'b00, 1'b1, 1'b1, 3'b000, 24'h3300E7},
        {1'b1, 2'b01, 1'b0, 1'b0, 3'b010, 24'h00FACE}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cfg_lsb_first = 1'b0;
    logic [1:0]  cfg_fs_len = 2'b00;
    logic        cfg_fs_early = 1'b0;
    logic        cfg_fs_active_low = 1'b0;
    logic [2:0]  cfg_word_len = 3'b000;
    logic [23:0] tx_word = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready, tx_data, tx_fs, tx_underrun;
    logic        rx_data = 1'b0;
    logic        rx_fs = 1'b0;
    logic [23:0] rx_word;
    logic        rx_valid;
    logic        rx_ready = 1'b0;
    logic        rx_overrun;

    int checks = 0;
    int failures = 0;
    int urun_cnt = 0;
    int orun_cnt = 0;
    int data_err, fs_err;
    logic [23:0] exp_tx;
    logic [23:0] rx_src [2];

    always #4 clk = ~clk;

    ssi_framer #(.FRAME_BITS(FRAME)) uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk),
        .cfg_lsb_first(cfg_lsb_first), .cfg_fs_len(cfg_fs_len),
        .cfg_fs_early(cfg_fs_early), .cfg_fs_active_low(cfg_fs_active_low),
        .cfg_word_len(cfg_word_len),
        .tx_word(tx_word), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_fs(tx_fs), .tx_underrun(tx_underrun),
        .rx_data(rx_data), .rx_fs(rx_fs), .rx_word(rx_word),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_overrun(rx_overrun)
    );

    always @(posedge clk) begin
        if (rst_n && tx_underrun) urun_cnt++;
        if (rst_n && rx_overrun)  orun_cnt++;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int wl_of(input logic [2:0] c);
        if (c == 3'b000) return 8;
        if (c == 3'b001) return 12;
        if (c == 3'b010) return 16;
        return 24;
    endfunction

    function automatic bit sync_on(input bit bitlen, input bit early, input int p, input int wl);
        if (bitlen) return p == 0;
        if (early)  return (p == FRAME - 1) || (p <= wl - 2);
        return p <= wl - 1;
    endfunction

    function automatic bit word_bit(input logic [23:0] w, input bit lsb, input int p, input int wl);
        if (p >= wl) return 1'b0;
        if (lsb) return w[p];
        return w[wl - 1 - p];
    endfunction

    function automatic bit tx_is_bit(input logic [1:0] c);
        return (c == 2'b01) || (c == 2'b10);
    endfunction

    function automatic bit rx_is_bit(input logic [1:0] c);
        return (c == 2'b10) || (c == 2'b11);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sclk = 1'b0; tx_valid = 1'b0; rx_ready = 1'b0; rx_data = 1'b0;
        repeat (4) @(negedge clk);
        rx_fs = cfg_fs_active_low;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        urun_cnt = 0; orun_cnt = 0;
    endtask

    task automatic push_word(input logic [23:0] w);
        @(negedge clk);
        tx_word = w; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    // One bit slot per k; the design's slot after rising edge k is p.
    task automatic run_slots(input int nslots);
        int wl;
        bit rxb, txb;
        wl = wl_of(cfg_word_len);
        rxb = rx_is_bit(cfg_fs_len);
        txb = tx_is_bit(cfg_fs_len);
        data_err = 0; fs_err = 0;
        for (int k = 1; k <= nslots; k++) begin
            int p, f;
            p = (k == 1) ? FRAME - 1 : (k - 2) % FRAME;
            f = (k < 2) ? 0 : (k - 2) / FRAME;
            if (f > 1) f = 1;
            @(negedge clk);
            sclk = 1'b1;
            rx_data = word_bit(rx_src[f], cfg_lsb_first, p, wl);
            rx_fs = sync_on(rxb, cfg_fs_early, p, wl) ^ cfg_fs_active_low;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
            repeat (4) @(negedge clk);
            if (tx_data !== word_bit(exp_tx, cfg_lsb_first, p, wl)) data_err++;
            if (tx_fs !== (sync_on(txb, cfg_fs_early, p, wl) ^ cfg_fs_active_low)) fs_err++;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        // R10: reset forces the controls to act as zero
        cfg_fs_active_low = 1'b1; cfg_word_len = 3'b011; cfg_lsb_first = 1'b1;
        repeat (6) @(negedge clk);
        check(tx_fs == 1'b0, "R10 tx_fs in reset", tx_fs, 0);
        check(tx_data == 1'b0, "R10 tx_data in reset", tx_data, 0);
        check(tx_ready == 1'b1, "R10 tx_ready in reset", tx_ready, 1);
        check(rx_valid == 1'b0, "R10 rx_valid in reset", rx_valid, 0);
        check(!tx_underrun && !rx_overrun, "R10 pulses in reset", {tx_underrun, rx_overrun}, 0);

        // Table walk: one frame per entry, transmit and receive together
        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] v;
            logic [23:0] exp_rx;
            int wl;
            v = VECS[i];
            cfg_lsb_first = v[31]; cfg_fs_len = v[30:29]; cfg_fs_early = v[28];
            cfg_fs_active_low = v[27]; cfg_word_len = v[26:24];
            wl = wl_of(cfg_word_len);
            exp_tx = v[23:0] & 24'((32'h1 << wl) - 1);
            rx_src[0] = v[23:0] ^ 24'h3C96A5;
            rx_src[1] = rx_src[0];
            exp_rx = rx_src[0] & 24'((32'h1 << wl) - 1);
            do_reset();
            push_word(v[23:0]);
            check(tx_ready == 1'b0, "R7 ready low after accept", tx_ready, 0);
            run_slots(FRAME + 1);
            check(data_err == 0, "R1 R6 tx data bits", data_err, 0);
            check(fs_err == 0, "R3 R4 R5 tx sync slots", fs_err, 0);
            check(rx_valid == 1'b1, "R2 rx word presented", rx_valid, 1);
            check(rx_word == exp_rx, "R2 R3 R4 R5 rx word", rx_word, exp_rx);
            check(urun_cnt == 0, "R7 no underrun with word loaded", urun_cnt, 0);
            @(negedge clk); rx_ready = 1'b1;
            @(negedge clk); rx_ready = 1'b0;
            check(rx_valid == 1'b0, "R9 rx_valid cleared by ready", rx_valid, 0);
        end

        // R8 and R9: two frames, one transmit word, no receive collection
        cfg_lsb_first = 1'b0; cfg_fs_len = 2'b00; cfg_fs_early = 1'b0;
        cfg_fs_active_low = 1'b0; cfg_word_len = 3'b000;
        exp_tx = 24'h0000A5;
        rx_src[0] = 24'h00005C; rx_src[1] = 24'h0000C3;
        do_reset();
        push_word(24'hFF00A5);
        check(tx_ready == 1'b0, "R7 ready low while word held", tx_ready, 0);
        run_slots(2 * FRAME + 1);
        check(data_err == 0, "R8 last word resent", data_err, 0);
        check(urun_cnt == 1, "R8 one underrun pulse", urun_cnt, 1);
        check(tx_ready == 1'b1, "R7 ready high after load", tx_ready, 1);
        check(orun_cnt == 1, "R9 one overrun pulse", orun_cnt, 1);
        check(rx_word == 24'h0000C3, "R9 newer word kept", rx_word, 24'h0000C3);
        check(rx_valid == 1'b1, "R9 valid held while unread", rx_valid, 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule